// File: doc/BRIEF.md
# Receive Frame Synchroniser and Destination Filter

This block sits behind a byte-wide demodulator and turns a raw byte stream into stored frames. It hunts for a run of zero bytes closed by a start delimiter. Once it is in sync, it passes each frame byte to an external receive FIFO through a write, mark, restore and patch port. While the bytes stream in, it decodes the frame control field and checks the destination PAN identifier and address at fixed byte positions. The position of that check depends on the addressing mode.

A frame that fails the filter is discarded by rewinding the FIFO write pointer to the mark set at the delimiter. The rest of that frame is consumed without being written. When a frame is accepted, the block checks its CRC. It then tells the FIFO to overwrite the two stored FCS bytes with a signal-strength byte and a quality byte, and it presents the frame type, sequence number, acknowledge request and CRC result with a one-cycle done pulse. If the FIFO fills during a frame, the block stops and stays silent until it is flushed.

Top module: `rx_frame_filter`

## Requirements
- R1: While hunting, a 0x7A byte that follows at least four consecutive 0x00 bytes (idle cycles between bytes allowed) raises `fifo_mark` in that same cycle and starts a frame. Any other non-zero byte, or a 0x7A after fewer than four zeros, clears the zero count. No byte is written while hunting.
- R2: Frame byte 0 is the length L. Bytes 0 through L are each written (`fifo_wr`, `fifo_wdata`) in the cycle they arrive. The frame ends with byte L.
- R3: Byte 1 bits 2:0 give `frame_type`. `ack_req` is byte 1 bit 5 for type 1 (data) or 3 (command), and 0 for every other type. Byte 3 is `seq_num`. All are valid while `frame_done` is high, which is the cycle after byte L.
- R4: With `filt_en` high, a frame is rejected at byte 2 in two cases: it is type 1 or 3 and byte 2 bits 3:2 are neither 2 (short) nor 3 (64-bit), or its type is 4 to 7. Types 0 and 2 skip the address check.
- R5: For a short destination (mode 2), the check is made when byte 7 arrives. Bytes 4,5 (PAN, low byte first) must equal `pan_id` or both be 0xFF. Bytes 6,7 must equal `short_addr` (low byte first) or both be 0xFF.
- R6: For a 64-bit destination (mode 3), the check is made when byte 13 arrives. The PAN rule is the same as in R5. Bytes 6..13 must equal `long_addr` (low byte first), and an all-0xFF address does not match.
- R7: On rejection, `fifo_restore` is high in the cycle of the deciding byte, and that byte is not written. The remaining bytes up to L are consumed unwritten, no `frame_done` follows, and hunting resumes.
- R8: The CRC uses the reflected polynomial 0x8408 with a zero seed, fed least significant bit first, over bytes 1..L-2. `crc_ok` is 1 when it equals {byte L-1, byte L}.
- R9: In the `frame_done` cycle, `fifo_patch_en` asks the FIFO to overwrite its two most recent bytes. The older one becomes `rssi` (sampled as byte L arrives) and the newer one becomes {`crc_ok`, `corr`}.
- R10: A frame byte that arrives while `fifo_full` is high sets `rx_overflow`. From then on nothing is written and no frame completes until a `flush` pulse, which returns the block to hunting.
- R11: With `filt_en` low, no frame is rejected, whatever its type or addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clears overflow and any frame in progress; returns to hunting |
| filt_en | input | 1 | Enables type and destination filtering |
| byte_vld | input | 1 | A demodulated byte is present this cycle |
| byte_data | input | 8 | Demodulated byte |
| pan_id | input | 16 | Own PAN identifier |
| short_addr | input | 16 | Own short address |
| long_addr | input | 64 | Own 64-bit address |
| rssi | input | 8 | Signal strength to store with the frame |
| corr | input | 7 | Correlation value to store with the frame |
| fifo_full | input | 1 | FIFO cannot take another byte |
| fifo_wr | output | 1 | Write `fifo_wdata` to the FIFO |
| fifo_wdata | output | 8 | Byte to write |
| fifo_mark | output | 1 | Remember the current write position |
| fifo_restore | output | 1 | Rewind the write position to the mark |
| fifo_patch_en | output | 1 | Overwrite the two most recently written bytes |
| fifo_patch_rssi | output | 8 | Value for the older of the two |
| fifo_patch_qual | output | 8 | Value for the newer of the two |
| frame_done | output | 1 | One-cycle pulse: an accepted frame has ended |
| frame_type | output | 3 | Frame type of the last frame |
| ack_req | output | 1 | Acknowledge requested by the last frame |
| seq_num | output | 8 | Sequence number of the last frame |
| crc_ok | output | 1 | CRC matched for the last frame |
| rx_overflow | output | 1 | Overflow state, left only by `flush` |

## Verification
The assertions assume that the external FIFO obeys every mark, restore and patch request in the cycle it is given. They also assume that `fifo_full` depends only on that FIFO's fill level and that `flush` is a lone pulse. The bench keeps to these assumptions with a small FIFO model whose full flag comes from its own write pointer and a cap that each test sets. It drives bytes only between clock edges, pulses `flush` once and only from the overflow test, and always sends frames long enough to reach the address check they exercise.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_FRAME, ST_DROP, ST_OVF} rx_state_e;

  localparam logic [2:0] FT_BEACON = 3'd0;
  localparam logic [2:0] FT_DATA   = 3'd1;
  localparam logic [2:0] FT_ACK    = 3'd2;
  localparam logic [2:0] FT_CMD    = 3'd3;
  localparam logic [1:0] AM_SHORT  = 2'd2;
  localparam logic [1:0] AM_LONG   = 2'd3;
  localparam logic [7:0] DELIM     = 8'h7A;

  // One byte of the reflected CCITT polynomial, LSB first
  function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  function automatic logic addr_mode_ok(input logic [1:0] m);
    return (m == AM_SHORT) || (m == AM_LONG);
  endfunction

  function automatic logic type_addressed(input logic [2:0] t);
    return (t == FT_DATA) || (t == FT_CMD);
  endfunction
endpackage

// File: rtl/rxf_sync_hunt.sv
`timescale 1ns/1ps
module rxf_sync_hunt #(
  parameter int ZEROS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hunt_en,
  input  logic       flush,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output logic       sync_hit
);
  import rxf_pkg::*;
  localparam int CW = $clog2(ZEROS + 1);

  logic [CW-1:0] zcnt;
  logic          enough;

  assign enough   = (zcnt == CW'(ZEROS));
  assign sync_hit = hunt_en && byte_vld && (byte_in == DELIM) && enough;

  always_ff @(posedge clk) begin
    if (!rst_n)                zcnt <= '0;
    else if (!hunt_en || flush) zcnt <= '0;
    else if (byte_vld) begin
      if (byte_in == 8'h00) zcnt <= enough ? zcnt : zcnt + 1'b1;
      else                  zcnt <= '0;
    end
  end

  // R1: a non-zero byte during the hunt leaves no zeros counted
  p_zero_run_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt_en && byte_vld && byte_in != 8'h00 && !flush) |=> (zcnt == '0));
  // R1: a hit is only possible on the delimiter
  p_hit_on_delim_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |-> (byte_in == DELIM && hunt_en));
endmodule

// File: rtl/rxf_crc_acc.sv
`timescale 1ns/1ps
module rxf_crc_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        step,
  input  logic [7:0]  byte_in,
  output logic [15:0] crc
);
  import rxf_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc <= '0;
    else if (clear) crc <= '0;
    else if (step)  crc <= fcs_step(crc, byte_in);
  end

  // R8: bytes outside the covered range leave the sum untouched
  p_crc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(crc));
endmodule

// File: rtl/rxf_addr_match.sv
`timescale 1ns/1ps
module rxf_addr_match #(
  parameter int IDX_W   = 8,
  parameter int PAN_W   = 16,
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 64,
  parameter int PAN_OFF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        byte_in,
  input  logic              long_mode,
  input  logic [PAN_W-1:0]  pan_id,
  input  logic [SHORT_W-1:0] short_addr,
  input  logic [LONG_W-1:0] long_addr,
  output logic              last_now,
  output logic              pass_now
);
  localparam int ADDR_OFF  = PAN_OFF + PAN_W / 8;
  localparam int SHORT_END = ADDR_OFF + SHORT_W / 8 - 1;
  localparam int LONG_END  = ADDR_OFF + LONG_W / 8 - 1;

  logic pan_m, pan_b, ad_m, ad_b;
  logic n_pan_m, n_pan_b, n_ad_m, n_ad_b;
  logic in_pan, in_ad;
  logic [IDX_W-1:0] pan_k, ad_k, end_idx;
  logic [PAN_W-1:0]   pan_sh;
  logic [SHORT_W-1:0] short_sh;
  logic [LONG_W-1:0]  long_sh;
  logic [7:0] ad_ref;

  always_comb begin
    end_idx  = long_mode ? IDX_W'(LONG_END) : IDX_W'(SHORT_END);
    pan_k    = idx - IDX_W'(PAN_OFF);
    ad_k     = idx - IDX_W'(ADDR_OFF);
    pan_sh   = pan_id >> (8 * pan_k);
    short_sh = short_addr >> (8 * ad_k);
    long_sh  = long_addr >> (8 * ad_k);
    in_pan   = (idx >= IDX_W'(PAN_OFF)) && (idx < IDX_W'(ADDR_OFF));
    in_ad    = (idx >= IDX_W'(ADDR_OFF)) && (idx <= end_idx);
    ad_ref   = long_mode ? long_sh[7:0] : short_sh[7:0];
    n_pan_m  = pan_m && (!in_pan || byte_in == pan_sh[7:0]);
    n_pan_b  = pan_b && (!in_pan || byte_in == 8'hFF);
    n_ad_m   = ad_m  && (!in_ad  || byte_in == ad_ref);
    n_ad_b   = ad_b  && (!in_ad  || byte_in == 8'hFF);
    last_now = (idx == end_idx);
    pass_now = (n_pan_m || n_pan_b) && (n_ad_m || (!long_mode && n_ad_b));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      pan_m <= 1'b1; pan_b <= 1'b1; ad_m <= 1'b1; ad_b <= 1'b1;
    end else if (step) begin
      pan_m <= n_pan_m; pan_b <= n_pan_b; ad_m <= n_ad_m; ad_b <= n_ad_b;
    end
  end

  // R5: a lost PAN match never comes back within a frame
  p_pan_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pan_m && !start) |=> !pan_m);
  // R6: a lost address match never comes back within a frame
  p_addr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ad_m && !start) |=> !ad_m);
endmodule

// File: rtl/rx_frame_filter.sv
`timescale 1ns/1ps
module rx_frame_filter #(
  parameter int ZEROS   = 4,
  parameter int IDX_W   = 8,
  parameter int PAN_W   = 16,
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 64,
  parameter int CORR_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               filt_en,
  input  logic               byte_vld,
  input  logic [7:0]         byte_data,
  input  logic [PAN_W-1:0]   pan_id,
  input  logic [SHORT_W-1:0] short_addr,
  input  logic [LONG_W-1:0]  long_addr,
  input  logic [7:0]         rssi,
  input  logic [CORR_W-1:0]  corr,
  input  logic               fifo_full,
  output logic               fifo_wr,
  output logic [7:0]         fifo_wdata,
  output logic               fifo_mark,
  output logic               fifo_restore,
  output logic               fifo_patch_en,
  output logic [7:0]         fifo_patch_rssi,
  output logic [7:0]         fifo_patch_qual,
  output logic               frame_done,
  output logic [2:0]         frame_type,
  output logic               ack_req,
  output logic [7:0]         seq_num,
  output logic               crc_ok,
  output logic               rx_overflow
);
  import rxf_pkg::*;

  rx_state_e        state;
  logic [IDX_W-1:0] idx, len;
  logic [7:0]       last_q, seq_q;
  logic [2:0]       ftype_q;
  logic [1:0]       mode_q;
  logic             ack_q, dec_q, done_q, crc_ok_q, patch_q;
  logic [7:0]       patch_rssi_q, patch_qual_q;
  logic [15:0]      crc;

  // Named internal events
  logic sync_hit, byte_go, ovf_hit, take, inpay, end_now, drop_end;
  logic type_rej, addr_rej, reject, crc_good, am_last, am_pass;

  rxf_sync_hunt #(.ZEROS(ZEROS)) u_hunt (
    .clk(clk), .rst_n(rst_n), .hunt_en(state == ST_HUNT), .flush(flush),
    .byte_vld(byte_vld), .byte_in(byte_data), .sync_hit(sync_hit));

  rxf_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clear(sync_hit), .step(take && inpay),
    .byte_in(byte_data), .crc(crc));

  rxf_addr_match #(.IDX_W(IDX_W), .PAN_W(PAN_W), .SHORT_W(SHORT_W),
                   .LONG_W(LONG_W), .PAN_OFF(4)) u_match (
    .clk(clk), .rst_n(rst_n), .start(sync_hit), .step(take && inpay),
    .idx(idx), .byte_in(byte_data), .long_mode(mode_q == AM_LONG),
    .pan_id(pan_id), .short_addr(short_addr), .long_addr(long_addr),
    .last_now(am_last), .pass_now(am_pass));

  always_comb begin
    byte_go  = byte_vld && (state == ST_FRAME) && !flush;
    ovf_hit  = byte_go && fifo_full;
    take     = byte_go && !fifo_full;
    inpay    = (idx != '0) && ({1'b0, idx} + 1'b1 < {1'b0, len});
    end_now  = (idx == '0) ? (byte_data == 8'h00) : (idx == len);
    drop_end = byte_vld && (state == ST_DROP) && (idx == len);
    type_rej = take && inpay && (idx == IDX_W'(2)) && filt_en &&
               ((type_addressed(ftype_q) && !addr_mode_ok(byte_data[3:2])) || ftype_q[2]);
    addr_rej = take && inpay && dec_q && am_last && !am_pass;
    reject   = type_rej || addr_rej;
    crc_good = (crc == {last_q, byte_data});
  end

  assign fifo_wr      = take && !reject;
  assign fifo_wdata   = byte_data;
  assign fifo_mark    = sync_hit;
  assign fifo_restore = reject;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_HUNT; idx <= '0; len <= '0; last_q <= '0;
      ftype_q <= '0; ack_q <= 1'b0; seq_q <= '0; mode_q <= '0; dec_q <= 1'b0;
      done_q <= 1'b0; patch_q <= 1'b0; crc_ok_q <= 1'b0;
      patch_rssi_q <= '0; patch_qual_q <= '0;
    end else begin
      done_q  <= 1'b0;
      patch_q <= 1'b0;
      if (flush) begin
        state <= ST_HUNT;
      end else begin
        case (state)
          ST_HUNT: if (sync_hit) begin
            state <= ST_FRAME; idx <= '0; dec_q <= 1'b0;
            ftype_q <= '0; ack_q <= 1'b0;
          end
          ST_FRAME: if (ovf_hit) begin
            state <= ST_OVF;
          end else if (take) begin
            idx    <= idx + 1'b1;
            last_q <= byte_data;
            if (idx == '0) len <= IDX_W'(byte_data);
            if (inpay && idx == IDX_W'(1)) begin
              ftype_q <= byte_data[2:0];
              ack_q   <= byte_data[5] && type_addressed(byte_data[2:0]);
            end
            if (inpay && idx == IDX_W'(2)) begin
              mode_q <= byte_data[3:2];
              dec_q  <= filt_en && type_addressed(ftype_q) && addr_mode_ok(byte_data[3:2]);
            end
            if (inpay && idx == IDX_W'(3)) seq_q <= byte_data;
            if (inpay && dec_q && am_last) dec_q <= 1'b0;
            if (reject) begin
              state <= ST_DROP;
            end else if (end_now) begin
              state        <= ST_HUNT;
              done_q       <= 1'b1;
              patch_q      <= 1'b1;
              crc_ok_q     <= crc_good;
              patch_rssi_q <= rssi;
              patch_qual_q <= {crc_good, corr};
            end
          end
          ST_DROP: if (byte_vld) begin
            idx <= idx + 1'b1;
            if (drop_end) state <= ST_HUNT;
          end
          default: ;
        endcase
      end
    end
  end

  assign fifo_patch_en   = patch_q;
  assign fifo_patch_rssi = patch_rssi_q;
  assign fifo_patch_qual = patch_qual_q;
  assign frame_done      = done_q;
  assign frame_type      = ftype_q;
  assign ack_req         = ack_q;
  assign seq_num         = seq_q;
  assign crc_ok          = crc_ok_q;
  assign rx_overflow     = (state == ST_OVF);

  // R1: the mark comes from the hunt and opens a frame
  p_mark_opens_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mark && !flush) |=> (state == ST_FRAME));
  // R2: bytes are written only while a frame is being taken
  p_wr_only_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (state == ST_FRAME));
  // R7: a rejection leads to the discard phase
  p_reject_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_restore && !flush) |=> (state == ST_DROP));
  // R7: a rejected frame never completes
  p_no_done_after_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DROP) |=> !frame_done);
  // R10: overflow is silent
  p_ovf_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> (!fifo_wr && !frame_done && !fifo_mark));
  // R9: a patch only follows a byte taken in the cycle before
  p_patch_after_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_patch_en |-> $past(fifo_wr));
endmodule

// File: tb/rx_frame_filter_tb.sv
`timescale 1ns/1ps
module rx_frame_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, filt_en = 1'b1, byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [15:0] pan_id = 16'h1234, short_addr = 16'hBEEF;
  logic [63:0] long_addr = 64'h0102030405060708;
  logic [7:0] rssi = 8'hC5;
  logic [6:0] corr = 7'h25;
  logic fifo_full, fifo_wr, fifo_mark, fifo_restore, fifo_patch_en;
  logic [7:0] fifo_wdata, fifo_patch_rssi, fifo_patch_qual, seq_num;
  logic frame_done, ack_req, crc_ok, rx_overflow;
  logic [2:0] frame_type;

  always #10 clk = ~clk;  // 50 MHz

  rx_frame_filter dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .filt_en(filt_en),
    .byte_vld(byte_vld), .byte_data(byte_data), .pan_id(pan_id),
    .short_addr(short_addr), .long_addr(long_addr), .rssi(rssi), .corr(corr),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .fifo_mark(fifo_mark), .fifo_restore(fifo_restore),
    .fifo_patch_en(fifo_patch_en), .fifo_patch_rssi(fifo_patch_rssi),
    .fifo_patch_qual(fifo_patch_qual), .frame_done(frame_done),
    .frame_type(frame_type), .ack_req(ack_req), .seq_num(seq_num),
    .crc_ok(crc_ok), .rx_overflow(rx_overflow));

  int checks = 0, fails = 0;

  // Receive FIFO model
  logic [7:0] mem [0:511];
  int wp = 0, mp = 0, cap = 100000;
  int done_cnt = 0;
  logic [7:0] cap_seq; logic [2:0] cap_type; logic cap_ack, cap_crc;
  assign fifo_full = (wp >= cap);

  always @(negedge clk) begin
    if (fifo_patch_en) begin
      mem[(wp - 2) & 511] = fifo_patch_rssi;
      mem[(wp - 1) & 511] = fifo_patch_qual;
    end
    if (fifo_mark) mp = wp;
    if (fifo_wr) begin mem[wp & 511] = fifo_wdata; wp = wp + 1; end
    if (fifo_restore) wp = mp;
    if (frame_done) begin
      done_cnt = done_cnt + 1;
      cap_seq = seq_num; cap_type = frame_type; cap_ack = ack_req; cap_crc = crc_ok;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Frame body under construction (bytes 1.. of the frame, before FCS)
  logic [7:0] fr [0:63];
  int fl = 0;
  task automatic fr_clear(); fl = 0; endtask
  task automatic fr_push(input logic [7:0] b); fr[fl] = b; fl++; endtask

  // CRC restated: MSB-first 0x1021 on bit-reversed bytes, result reversed
  function automatic logic [15:0] ref_crc();
    logic [15:0] c; logic [7:0] rb; logic fb; logic [15:0] o;
    c = 16'h0;
    for (int k = 0; k < fl; k++) begin
      for (int j = 0; j < 8; j++) rb[j] = fr[k][7-j];
      for (int j = 7; j >= 0; j--) begin
        fb = c[15] ^ rb[j];
        c = c << 1;
        if (fb) c = c ^ 16'h1021;
      end
    end
    for (int j = 0; j < 16; j++) o[j] = c[15-j];
    return o;
  endfunction

  task automatic put(input logic [7:0] b);
    @(posedge clk); #2; byte_vld = 1'b1; byte_data = b;
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #2; byte_vld = 1'b0; end
  endtask

  task automatic send_frame(input int nz, input bit bad_fcs);
    logic [15:0] c;
    c = ref_crc();
    for (int k = 0; k < nz; k++) put(8'h00);
    put(8'h7A);
    put(8'(fl + 2));
    for (int k = 0; k < fl; k++) put(fr[k]);
    put(c[15:8]);
    put(bad_fcs ? ~c[7:0] : c[7:0]);
    idle(4);
  endtask

  task automatic body_short(input logic [7:0] f0, input logic [7:0] f1,
                            input logic [15:0] pan, input logic [15:0] sa);
    fr_clear(); fr_push(f0); fr_push(f1); fr_push(8'h5A);
    fr_push(pan[7:0]); fr_push(pan[15:8]); fr_push(sa[7:0]); fr_push(sa[15:8]);
    fr_push(8'hAA); fr_push(8'hBB);
  endtask

  task automatic body_long(input logic [15:0] pan, input logic [63:0] la);
    fr_clear(); fr_push(8'h21); fr_push(8'h0C); fr_push(8'h77);
    fr_push(pan[7:0]); fr_push(pan[15:8]);
    for (int k = 0; k < 8; k++) fr_push(la[8*k +: 8]);
    fr_push(8'h3C);
  endtask

  // Accepted-frame expectations
  task automatic expect_accept(input string req, input int w0, input int d0,
                               input logic [7:0] sq, input int ty, input int ak, input int ck);
    chk({req, " done"}, done_cnt - d0, 1);
    chk({req, " len stored"}, wp - w0, fl + 3);
    chk({req, " first byte is length"}, mem[w0 & 511], fl + 2);
    chk({req, " seq"}, cap_seq, sq);
    chk({req, " type"}, cap_type, ty);
    chk({req, " ack"}, cap_ack, ak);
    chk({req, " crc_ok"}, cap_crc, ck);
    chk({req, " R9 rssi patch"}, mem[(wp - 2) & 511], 8'hC5);
    chk({req, " R9 qual patch"}, mem[(wp - 1) & 511], {ck[0], 7'h25});
  endtask

  task automatic expect_reject(input string req, input int w0, input int d0);
    chk({req, " no done"}, done_cnt - d0, 0);
    chk({req, " write pointer rewound"}, wp, w0);
  endtask

  task automatic t_reset();
    chk("R2 reset wr", fifo_wr, 0);
    chk("R3 reset done", frame_done, 0);
    chk("R10 reset ovf", rx_overflow, 0);
  endtask

  task automatic t_short_good();  // R2 R3 R5 R8 R9
    int w0 = wp, d0 = done_cnt;
    body_short(8'h21, 8'h08, 16'h1234, 16'hBEEF);
    send_frame(4, 0);
    expect_accept("R5 short match", w0, d0, 8'h5A, 1, 1, 1);
    chk("R2 fcf stored", mem[(w0 + 1) & 511], 8'h21);
  endtask

  task automatic t_bad_crc();  // R8
    int w0 = wp, d0 = done_cnt;
    body_short(8'h21, 8'h08, 16'h1234, 16'hBEEF);
    send_frame(4, 1);
    expect_accept("R8 bad fcs", w0, d0, 8'h5A, 1, 1, 0);
  endtask

  task automatic t_short_miss();  // R5 R7
    int w0 = wp, d0 = done_cnt;
    body_short(8'h21, 8'h08, 16'h1234, 16'hBFEF);
    send_frame(4, 0);
    expect_reject("R7 short addr miss", w0, d0);
    w0 = wp; d0 = done_cnt;
    body_short(8'h21, 8'h08, 16'hFFFF, 16'hBEEF);
    send_frame(4, 0);
    expect_accept("R7 resumes after drop", w0, d0, 8'h5A, 1, 1, 1);
    w0 = wp; d0 = done_cnt;
    body_short(8'h21, 8'h08, 16'h1235, 16'hBEEF);
    send_frame(4, 0);
    expect_reject("R5 pan miss", w0, d0);
  endtask

  task automatic t_bcast();  // R5
    int w0 = wp, d0 = done_cnt;
    body_short(8'h01, 8'h08, 16'hFFFF, 16'hFFFF);
    send_frame(4, 0);
    expect_accept("R5 broadcast", w0, d0, 8'h5A, 1, 0, 1);
  endtask

  task automatic t_long();  // R6
    int w0 = wp, d0 = done_cnt;
    body_long(16'h1234, 64'h0102030405060708);
    send_frame(4, 0);
    expect_accept("R6 long match", w0, d0, 8'h77, 1, 1, 1);
    w0 = wp; d0 = done_cnt;
    body_long(16'hFFFF, 64'h0202030405060708);
    send_frame(4, 0);
    expect_reject("R6 long last byte miss", w0, d0);
    w0 = wp; d0 = done_cnt;
    body_long(16'h1234, 64'hFFFFFFFFFFFFFFFF);
    send_frame(4, 0);
    expect_reject("R6 long all-ones", w0, d0);
  endtask

  task automatic t_modes();  // R4 R11
    int w0 = wp, d0 = done_cnt;
    body_short(8'h21, 8'h00, 16'h0000, 16'h0000);
    send_frame(4, 0);
    expect_reject("R4 data mode 0", w0, d0);
    w0 = wp; d0 = done_cnt;
    fr[0] = 8'h05; fr[1] = 8'h08;
    send_frame(4, 0);
    expect_reject("R4 type 5", w0, d0);
    w0 = wp; d0 = done_cnt;
    body_short(8'h20, 8'h08, 16'h0000, 16'h0000);
    send_frame(4, 0);
    expect_accept("R4 beacon skips filter", w0, d0, 8'h5A, 0, 0, 1);
    filt_en = 1'b0;
    w0 = wp; d0 = done_cnt;
    body_short(8'h21, 8'h00, 16'h0000, 16'h0000);
    send_frame(4, 0);
    expect_accept("R11 filter off", w0, d0, 8'h5A, 1, 1, 1);
    filt_en = 1'b1;
  endtask

  task automatic t_sync();  // R1
    int w0 = wp, d0 = done_cnt;
    put(8'h00); put(8'h00); put(8'h00); put(8'h7A);
    put(8'h09); put(8'h21); put(8'h08);
    put(8'h00); put(8'h00); put(8'h00); put(8'h11); put(8'h00); put(8'h7A);
    idle(3);
    chk("R1 short run ignored", wp, w0);
    chk("R1 no frame", done_cnt, d0);
    body_short(8'h21, 8'h08, 16'h1234, 16'hBEEF);
    put(8'h00); put(8'h00); idle(2);  // gap between zeros is allowed
    send_frame(3, 0);
    expect_accept("R1 long preamble", w0, d0, 8'h5A, 1, 1, 1);
  endtask

  task automatic t_overflow();  // R10
    int w0 = wp, d0 = done_cnt;
    cap = wp + 6;
    body_short(8'h21, 8'h08, 16'h1234, 16'hBEEF);
    send_frame(4, 0);
    chk("R10 overflow flag", rx_overflow, 1);
    chk("R10 writes stop at full", wp, w0 + 6);
    chk("R10 no done", done_cnt, d0);
    cap = 100000;
    send_frame(4, 0);
    chk("R10 stuck until flush", wp, w0 + 6);
    @(posedge clk); #2; flush = 1'b1;
    @(posedge clk); #2; flush = 1'b0;
    @(negedge clk);
    chk("R10 flush clears", rx_overflow, 0);
    w0 = wp; d0 = done_cnt;
    send_frame(4, 0);
    expect_accept("R10 after flush", w0, d0, 8'h5A, 1, 1, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_good();
    t_bad_crc();
    t_short_miss();
    t_bcast();
    t_long();
    t_modes();
    t_sync();
    t_overflow();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule